// File: doc/BRIEF.md
# SD Card Capacity Decoder

This block turns the 128-bit card-specific data word that a memory card returns during identification into a usable disk geometry: the size of one sector in bytes and the total number of sectors. A host controller or boot engine presents the whole word together with a one-cycle strobe. One clock later the decoder presents the geometry with its own one-cycle valid pulse.

The card's structure version decides how capacity is encoded. With the older layout, capacity comes from a 12-bit size field and a 3-bit exponent multiplier. With the newer high-capacity layout, it comes from a 22-bit size field counted in 512 KiB units. The newer layout's sector count is obtained by scaling by the sector size. That division is done as a shift, because the sector size is always a power of two. Geometries with 1024-byte sectors are rewritten as twice as many 512-byte sectors. Structure versions that neither layout covers raise a flag and report an empty geometry.

Top module: `csd_capacity_decoder`

## Requirements
- R1: `out_valid` is high in exactly the cycle that follows each cycle in which `in_valid` is high, and low otherwise.
- R2: When `in_valid` is low, `sec_size`, `sec_count` and `unsupported` keep their previous values, whatever `csd_in` carries.
- R3: For a supported word whose size exponent (bits 83..80) is not 10, `sec_size` equals 2 raised to that exponent.
- R4: The two-bit structure version in bits 127..126 selects the capacity formula: value 0 selects the older layout and value 1 selects the high-capacity layout.
- R5: Older layout: `sec_count` = (bits 73..62 + 1) × 2^(bits 49..47 + 2).
- R6: High-capacity layout: `sec_count` = (bits 69..48 + 1) × 524288 / `sec_size`, computed before any rescaling.
- R7: When the decoded sector size is 1024, the reported count is doubled and `sec_size` reads 512, for either layout.
- R8: Structure versions 2 and 3 set `unsupported` to 1 and report `sec_count` = 0 and `sec_size` = 0. Supported versions report `unsupported` = 0.
- R9: After reset, `out_valid`, `unsupported`, `sec_size` and `sec_count` are all 0.
- R10: Strobes on consecutive cycles each produce their own result, in order, on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe marking `csd_in` as a word to decode |
| csd_in | input | 128 | Card-specific data word |
| out_valid | output | 1 | One-cycle pulse marking a fresh result |
| sec_size | output | 16 | Sector size in bytes |
| sec_count | output | 64 | Total number of sectors |
| unsupported | output | 1 | Structure version has no known layout |

## Verification
The hardest combinations to reach are the extremes of the capacity arithmetic. One is a high-capacity word with the smallest size exponent and a full size field, whose count needs more than 40 bits. Another is the 1024-byte case on each layout, where the shift and the rescaling must combine correctly. The stimulus builds those words on purpose, field by field, over a busy filler pattern. The filler shows that the unused bits do not leak into the result. Back-to-back strobes, and idle stretches with a changing input word, cover the pulse timing and the hold behaviour.

// File: rtl/csdcap_pkg.sv
package csdcap_pkg;

   // Field positions inside the card-specific data word
   localparam int VER_HI     = 127;
   localparam int VER_LO     = 126;
   localparam int EXP_HI     = 83;
   localparam int EXP_LO     = 80;
   localparam int L1_SIZE_HI = 73;
   localparam int L1_SIZE_LO = 62;
   localparam int L1_MULT_HI = 49;
   localparam int L1_MULT_LO = 47;
   localparam int L2_SIZE_HI = 69;
   localparam int L2_SIZE_LO = 48;

   localparam int EXP_W     = EXP_HI - EXP_LO + 1;
   localparam int L1_SIZE_W = L1_SIZE_HI - L1_SIZE_LO + 1;
   localparam int L1_MULT_W = L1_MULT_HI - L1_MULT_LO + 1;
   localparam int L2_SIZE_W = L2_SIZE_HI - L2_SIZE_LO + 1;

   // High-capacity unit is 512 KiB = 2^19 bytes
   localparam int L2_UNIT_LOG2 = 19;
   // 1024-byte sectors are rescaled to 512-byte sectors
   localparam int KB_EXP   = 10;
   localparam int HALF_EXP = 9;

   typedef enum logic [1:0] {
      LAYOUT_STD  = 2'd0,
      LAYOUT_HC   = 2'd1,
      LAYOUT_RSV2 = 2'd2,
      LAYOUT_RSV3 = 2'd3
   } layout_e;

   typedef struct packed {
      layout_e                ver;
      logic [EXP_W-1:0]       blk_exp;
      logic [L1_SIZE_W-1:0]   l1_size;
      logic [L1_MULT_W-1:0]   l1_mult;
      logic [L2_SIZE_W-1:0]   l2_size;
   } csd_fields_t;

endpackage

// File: rtl/csdcap_field_split.sv
module csdcap_field_split
   import csdcap_pkg::*;
#(
   parameter int CSD_W = 128
) (
   input  logic [CSD_W-1:0] csd_in,
   output csd_fields_t      fields
);

   assign fields.ver     = layout_e'(csd_in[VER_HI:VER_LO]);
   assign fields.blk_exp = csd_in[EXP_HI:EXP_LO];
   assign fields.l1_size = csd_in[L1_SIZE_HI:L1_SIZE_LO];
   assign fields.l1_mult = csd_in[L1_MULT_HI:L1_MULT_LO];
   assign fields.l2_size = csd_in[L2_SIZE_HI:L2_SIZE_LO];

   // Bits with no bearing on capacity
   logic unused_bits;
   assign unused_bits = ^{csd_in[CSD_W-1:VER_HI+1], csd_in[VER_LO-1:EXP_HI+1],
                          csd_in[EXP_LO-1:L1_SIZE_HI+1], csd_in[L1_MULT_LO-1:0]};

endmodule

// File: rtl/csdcap_std_calc.sv
module csdcap_std_calc
   import csdcap_pkg::*;
#(
   parameter int COUNT_W = 64
) (
   input  logic [L1_SIZE_W-1:0] size_fld,
   input  logic [L1_MULT_W-1:0] mult_fld,
   output logic [COUNT_W-1:0]   count
);

   localparam int SHIFT_W = L1_MULT_W + 1;

   logic [COUNT_W-1:0] base;
   logic [SHIFT_W-1:0] shamt;

   always_comb begin
      base  = COUNT_W'(size_fld) + COUNT_W'(1);
      shamt = SHIFT_W'(mult_fld) + SHIFT_W'(2);
      count = base << shamt;
   end

endmodule

// File: rtl/csdcap_hc_calc.sv
module csdcap_hc_calc
   import csdcap_pkg::*;
#(
   parameter int COUNT_W = 64
) (
   input  logic [L2_SIZE_W-1:0] size_fld,
   input  logic [EXP_W-1:0]     blk_exp,
   output logic [COUNT_W-1:0]   count
);

   // units * 2^19 / 2^exp == units << (19 - exp); exp <= 15 keeps this positive
   localparam int SHIFT_W = 5;

   logic [COUNT_W-1:0] units;
   logic [SHIFT_W-1:0] shamt;

   always_comb begin
      units = COUNT_W'(size_fld) + COUNT_W'(1);
      shamt = SHIFT_W'(L2_UNIT_LOG2) - SHIFT_W'(blk_exp);
      count = units << shamt;
   end

endmodule

// File: rtl/csdcap_rescale.sv
module csdcap_rescale
   import csdcap_pkg::*;
#(
   parameter int COUNT_W = 64,
   parameter int SIZE_W  = 16,
   parameter bit NORM_1K = 1'b1
) (
   input  logic [EXP_W-1:0]   blk_exp,
   input  logic [COUNT_W-1:0] count_in,
   output logic [COUNT_W-1:0] count_out,
   output logic [SIZE_W-1:0]  size_out
);

   logic [SIZE_W-1:0] raw_size;
   assign raw_size = SIZE_W'(1) << blk_exp;

   generate
      if (NORM_1K) begin : g_norm
         always_comb begin
            if (blk_exp == EXP_W'(KB_EXP)) begin
               count_out = count_in << 1;
               size_out  = SIZE_W'(1) << HALF_EXP;
            end else begin
               count_out = count_in;
               size_out  = raw_size;
            end
         end
      end else begin : g_pass
         assign count_out = count_in;
         assign size_out  = raw_size;
      end
   endgenerate

endmodule

// File: rtl/csd_capacity_decoder.sv
module csd_capacity_decoder
   import csdcap_pkg::*;
#(
   parameter int CSD_W   = 128,
   parameter int COUNT_W = 64,
   parameter int SIZE_W  = 16,
   parameter bit NORM_1K = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [CSD_W-1:0]   csd_in,
   output logic               out_valid,
   output logic [SIZE_W-1:0]  sec_size,
   output logic [COUNT_W-1:0] sec_count,
   output logic               unsupported
);

   // Largest count: 2^22 units << 19, doubled on rescale -> 43 bits
   localparam int MIN_COUNT_W = L2_SIZE_W + L2_UNIT_LOG2 + 2;
   localparam int MIN_SIZE_W  = (1 << EXP_W);

   generate
      if (CSD_W != 128) begin : g_bad_csd
         $error("csd_capacity_decoder: CSD_W must be 128");
      end
      if (COUNT_W < MIN_COUNT_W) begin : g_bad_count
         $error("csd_capacity_decoder: COUNT_W too narrow");
      end
      if (SIZE_W < MIN_SIZE_W) begin : g_bad_size
         $error("csd_capacity_decoder: SIZE_W too narrow");
      end
   endgenerate

   csd_fields_t        fld;
   logic [COUNT_W-1:0] std_count;
   logic [COUNT_W-1:0] hc_count;
   logic [COUNT_W-1:0] pick_count;
   logic [COUNT_W-1:0] norm_count;
   logic [SIZE_W-1:0]  norm_size;
   logic               bad_ver;

   csdcap_field_split #(.CSD_W(CSD_W)) u_split (
      .csd_in (csd_in),
      .fields (fld)
   );

   csdcap_std_calc #(.COUNT_W(COUNT_W)) u_std (
      .size_fld (fld.l1_size),
      .mult_fld (fld.l1_mult),
      .count    (std_count)
   );

   csdcap_hc_calc #(.COUNT_W(COUNT_W)) u_hc (
      .size_fld (fld.l2_size),
      .blk_exp  (fld.blk_exp),
      .count    (hc_count)
   );

   always_comb begin
      bad_ver    = 1'b0;
      pick_count = '0;
      unique case (fld.ver)
         LAYOUT_STD: pick_count = std_count;
         LAYOUT_HC:  pick_count = hc_count;
         default:    bad_ver    = 1'b1;
      endcase
   end

   csdcap_rescale #(.COUNT_W(COUNT_W), .SIZE_W(SIZE_W), .NORM_1K(NORM_1K)) u_rescale (
      .blk_exp   (fld.blk_exp),
      .count_in  (pick_count),
      .count_out (norm_count),
      .size_out  (norm_size)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         sec_size    <= '0;
         sec_count   <= '0;
         unsupported <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            unsupported <= bad_ver;
            sec_count   <= bad_ver ? '0 : norm_count;
            sec_size    <= bad_ver ? '0 : norm_size;
         end
      end
   end

endmodule

// File: rtl/csdcap_checker.sv
module csdcap_checker #(
   parameter int CSD_W   = 128,
   parameter int COUNT_W = 64,
   parameter int SIZE_W  = 16,
   parameter bit NORM_1K = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [CSD_W-1:0]   csd_in,
   input logic               out_valid,
   input logic [SIZE_W-1:0]  sec_size,
   input logic [COUNT_W-1:0] sec_count,
   input logic               unsupported
);

   assert_strobe_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   assert_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(sec_count) && $stable(sec_size) && $stable(unsupported)));

   assert_unsup_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && csd_in[127]) |=> unsupported);

   assert_unsup_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      unsupported |-> (sec_count == '0 && sec_size == '0));

   assert_pow2_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !unsupported) |-> ($countones(sec_size) == 1));

   generate
      if (NORM_1K) begin : g_norm_chk
         assert_no_1k_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !unsupported) |-> (sec_size != SIZE_W'(1024)));
      end
   endgenerate

endmodule

bind csd_capacity_decoder csdcap_checker #(
   .CSD_W(CSD_W), .COUNT_W(COUNT_W), .SIZE_W(SIZE_W), .NORM_1K(NORM_1K)
) u_chk (.*);

// File: tb/csd_capacity_decoder_bench.sv
module csd_capacity_decoder_bench;

   typedef struct {
      logic [63:0] cnt;
      logic [15:0] sz;
      logic        uns;
      string       tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n;
   logic         in_valid;
   logic [127:0] csd_in;
   logic         out_valid;
   logic [15:0]  sec_size;
   logic [63:0]  sec_count;
   logic         unsupported;

   int   checks   = 0;
   int   failures = 0;
   exp_t q[$];
   exp_t last;
   logic [127:0] filler = {4{32'hA5C3_3C5A}};

   always #10 clk = ~clk;

   csd_capacity_decoder u_csd_capacity_decoder (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .csd_in(csd_in),
      .out_valid(out_valid), .sec_size(sec_size), .sec_count(sec_count),
      .unsupported(unsupported)
   );

   function automatic exp_t model(input logic [127:0] c, input string tag);
      exp_t e;
      logic [63:0] size64;
      e.tag = tag;
      e.uns = 1'b0;
      size64 = 64'd1 << c[83:80];
      case (c[127:126])
         2'd0: e.cnt = (64'(c[73:62]) + 64'd1) * (64'd1 << (c[49:47] + 4'd2));
         2'd1: e.cnt = ((64'(c[69:48]) + 64'd1) * 64'd524288) / size64;
         default: begin e.uns = 1'b1; e.cnt = 64'd0; size64 = 64'd0; end
      endcase
      if (!e.uns && size64 == 64'd1024) begin
         e.cnt  = e.cnt * 64'd2;
         size64 = 64'd512;
      end
      e.sz = size64[15:0];
      return e;
   endfunction

   function automatic logic [127:0] mk_std(input logic [3:0] ex, input logic [11:0] sz,
                                           input logic [2:0] mu);
      logic [127:0] c = {4{32'h5A3C_96E1}};
      c[127:126] = 2'd0; c[83:80] = ex; c[73:62] = sz; c[49:47] = mu;
      return c;
   endfunction

   function automatic logic [127:0] mk_hc(input logic [3:0] ex, input logic [21:0] sz);
      logic [127:0] c = {4{32'hC3A5_1F0E}};
      c[127:126] = 2'd1; c[83:80] = ex; c[69:48] = sz;
      return c;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   task automatic send(input logic [127:0] c, input string tag);
      @(negedge clk);
      in_valid = 1'b1;
      csd_in   = c;
      q.push_back(model(c, tag));
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         filler   = {filler[126:0], filler[127] ^ filler[100]};
         csd_in   = filler;
      end
   endtask

   // R2 hold: after idle cycles the outputs still show the last result
   task automatic hold_check();
      idle(3);
      check(out_valid == 1'b0, "R1", "idle out_valid", 64'(out_valid), 64'd0);
      check(sec_count == last.cnt && sec_size == last.sz && unsupported == last.uns,
            "R2", "held outputs", sec_count, last.cnt);
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n === 1'b1 && out_valid === 1'b1) begin
         if (q.size() == 0) begin
            check(1'b0, "R1", "unexpected out_valid", 64'd1, 64'd0);
         end else begin
            exp_t e;
            e = q.pop_front();
            check(sec_count == e.cnt, "R5/R6 count", e.tag, sec_count, e.cnt);
            check(sec_size == e.sz, "R3/R7 size", e.tag, 64'(sec_size), 64'(e.sz));
            check(unsupported == e.uns, "R8 flag", e.tag, 64'(unsupported), 64'(e.uns));
            last = e;
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "R1", "watchdog expired", 64'd0, 64'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst_n    = 1'b0;
      in_valid = 1'b0;
      csd_in   = '0;
      repeat (3) @(negedge clk);
      // R9 reset state
      check(out_valid == 1'b0 && unsupported == 1'b0, "R9", "reset flags",
            64'({out_valid, unsupported}), 64'd0);
      check(sec_count == 64'd0 && sec_size == 16'd0, "R9", "reset geometry",
            sec_count, 64'd0);
      rst_n = 1'b1;
      idle(2);

      // R4/R5 older layout, largest fields, 512-byte sectors: 4096<<9
      send(mk_std(4'd9, 12'hFFF, 3'd7), "R5 std max");
      idle(2);
      // R7 older layout with 1024-byte sectors: 101<<4 doubled
      send(mk_std(4'd10, 12'd100, 3'd2), "R7 std 1k");
      idle(2);
      // R3 older layout with 2048-byte sectors kept as is
      send(mk_std(4'd11, 12'd0, 3'd0), "R3 std 2k");
      hold_check();
      // R4/R6 high-capacity, full size field, 512 bytes: 2^32
      send(mk_hc(4'd9, 22'h3FFFFF), "R6 hc full");
      idle(2);
      // R7 high-capacity with 1024-byte sectors
      send(mk_hc(4'd10, 22'd7), "R7 hc 1k");
      idle(2);
      // R6 largest exponent (32768 bytes)
      send(mk_hc(4'd15, 22'd1), "R6 hc 32k");
      idle(2);
      // R6 smallest exponent, widest count 2^41
      send(mk_hc(4'd0, 22'h3FFFFF), "R6 hc exp0");
      hold_check();
      // R8 reserved versions
      begin
         logic [127:0] c;
         c = filler; c[127:126] = 2'd2;
         send(c, "R8 ver2");
         idle(2);
         c = ~filler; c[127:126] = 2'd3;
         send(c, "R8 ver3");
      end
      hold_check();
      // R10 back-to-back strobes
      send(mk_std(4'd9, 12'd5, 3'd1), "R10 b2b a");
      send(mk_hc(4'd12, 22'd1000), "R10 b2b b");
      send(mk_std(4'd10, 12'd77, 3'd6), "R10 b2b c");
      send(mk_hc(4'd10, 22'd0), "R10 b2b d");
      hold_check();
      idle(3);
      check(q.size() == 0, "R1", "results outstanding", 64'(q.size()), 64'd0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule